// File: doc/BRIEF.md
# Dual-Prescaler PWM Channel

This block produces one pulse-width-modulated pin. The input clock is cut into time quanta by two prescaler stages in series. The first stage divides by a linear count. The second stage divides by a power of two. A period counter then steps once per quantum and restarts after a programmable last value. The pin is active between a rising compare point and a falling compare point. The window may wrap around the end of the period, and equal points give a pin that is always active.

Software writes two words. The control word holds the divider fields, run, pin drive, open-drain, inversion and the sync-bypass bit. The duty word holds the period's last count and the two compare points. Duty-word updates are normally held back until the period wraps, so no period mixes old and new settings. With sync bypass set they apply on the next clock. Control-word fields act on the next clock. That includes the enables, so switching off does not wait for the current period to end.

Top module: `dpwm_channel`

## Requirements
- R1: After a synchronous active-low reset, pwm_out and pwm_oe are both 0.
- R2: A quantum lasts (DL+1)<<DH input clocks, where DL is control bits 7:0 and DH is control bits 11:8. A period lasts (LAST+1) quanta, where LAST is duty bits 23:16. The period counter starts at 0 when run goes high.
- R3: Let RISE be duty bits 7:0, FALL be duty bits 15:8 and CNT be the period count. If RISE<FALL, the pin is active while RISE<=CNT<FALL. If RISE>FALL, it is active while CNT>=RISE or CNT<FALL.
- R4: When RISE equals FALL, the pin is active for the whole period.
- R5: While run (control bit 15) is 0, the period counter and the prescaler are held at 0 and the pin shows the inactive level from the next clock on.
- R6: While pin drive (control bit 12) is 0, pwm_oe is 0 and pwm_out shows the inactive level. The inactive level is 0, or 1 when inverted. This takes effect on the clock after the write.
- R7: Inversion (control bit 14) flips pwm_out on the clock after the write, without waiting for a period boundary.
- R8: With sync bypass (control bit 16) at 0 and run at 1, a written duty word takes effect only when the period counter wraps. While run is 0, it takes effect on the next clock.
- R9: With sync bypass at 1, a written duty word takes effect on the next clock.
- R10: With open-drain (control bit 13) at 1, pwm_oe is 0 whenever pwm_out is 1, so the pin only ever drives low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 17 | Control word value |
| duty_wr | input | 1 | Write strobe for the duty word |
| duty_wdata | input | 24 | Duty word value |
| pwm_out | output | 1 | Pin level |
| pwm_oe | output | 1 | Pin output enable |

## Verification
Every result of this block is due one clock after the edge that causes it. A register write changes the outputs one clock after its strobe edge. A quantum tick moves the counter, and so the pin, one clock after that tick. The bench drives inputs on falling edges. It keeps a behavioural model that steps on the same rising edges, and it compares both outputs with the model on every falling edge, once that one-clock latency has settled. The duty-ratio checks count high cycles over whole numbers of periods, so the phase of the counter does not affect the expected count.

// File: rtl/dpwm_pkg.sv
// Shared widths, word layouts and decoded types for the PWM channel.
// Assumes the control and duty word layouts given in the brief.
package dpwm_pkg;
    parameter int DIVL_W = 8;   // linear prescaler field width
    parameter int DIVH_W = 4;   // power-of-two prescaler field width
    parameter int CNT_W  = 8;   // period counter width

    localparam int CTRL_W   = DIVL_W + DIVH_W + 5;
    localparam int DUTY_W   = 3 * CNT_W;
    localparam int B_DRIVE  = DIVL_W + DIVH_W;
    localparam int B_OD     = B_DRIVE + 1;
    localparam int B_INV    = B_DRIVE + 2;
    localparam int B_RUN    = B_DRIVE + 3;
    localparam int B_SYNCOFF = B_DRIVE + 4;

    typedef struct packed {
        logic              sync_off;
        logic              run;
        logic              inv;
        logic              od;
        logic              drive;
        logic [DIVH_W-1:0] dh;
        logic [DIVL_W-1:0] dl;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] last;
        logic [CNT_W-1:0] fall;
        logic [CNT_W-1:0] rise;
    } duty_t;
endpackage

// File: rtl/dpwm_prescaler.sv
// Two-stage quantum generator: a linear stage dividing by DL+1 feeding a
// counter that divides by 2**DH. Emits a one-clock tick per quantum.
// Assumes divider fields change only while run is low.
module dpwm_prescaler #(
    parameter int DIVL_W = 8,
    parameter int DIVH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIVL_W-1:0] dl,
    input  logic [DIVH_W-1:0] dh,
    output logic              tick
);
    localparam int C2_W = (1 << DIVH_W) - 1;

    logic [DIVL_W-1:0] c1;
    logic [C2_W-1:0]   c2;
    logic [C2_W-1:0]   c2_top;
    logic              step;

    assign c2_top = ~({C2_W{1'b1}} << dh);
    assign step   = run && (c1 >= dl);
    assign tick   = step && (c2 >= c2_top);

    // Linear stage: count input clocks up to DL, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  c1 <= '0;
        else if (step)       c1 <= '0;
        else                 c1 <= c1 + 1'b1;
    end

    // Power-of-two stage: count linear-stage steps up to 2**DH-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  c2 <= '0;
        else if (tick)       c2 <= '0;
        else if (step)       c2 <= c2 + 1'b1;
    end

    // R2: with DL nonzero and unchanged, two ticks never fall on adjacent clocks
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(tick) && $past(dl) != '0 && dl == $past(dl)) |-> !tick);
endmodule

// File: rtl/dpwm_period.sv
// Period counter with a shadowed duty word. Writes land in a pending
// register and move to the live copy at the period wrap, at once when
// sync is bypassed, or continuously while the channel is stopped.
module dpwm_period
    import dpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_off,
    input  logic             tick,
    input  logic             wr,
    input  duty_t            wdata,
    output logic [CNT_W-1:0] cnt,
    output duty_t            live
);
    duty_t pend;
    duty_t incoming;
    logic  wrap;

    assign incoming = wr ? wdata : pend;
    assign wrap     = tick && (cnt >= live.last);

    // Pending copy: hold the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n)  pend <= '0;
        else         pend <= incoming;
    end

    // Live copy: load at the wrap, when bypassed, or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                       live <= '0;
        else if (sync_off || !run || wrap) live <= incoming;
    end

    // Period counter: step per quantum, wrap after LAST, hold 0 while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (wrap)       cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    // R5: a stopped channel has its counter at zero on the next clock
    p_stopped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R8: in synced running mode the live settings move only at the wrap
    p_live_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_off && !wrap) |=> $stable(live));
endmodule

// File: rtl/dpwm_outstage.sv
// Compare and pin stage: decides the active window from the count and
// the compare points, then applies run/drive gating, inversion and
// open-drain. Purely combinational.
module dpwm_outstage
    import dpwm_pkg::*;
(
    input  logic             run,
    input  logic             drive,
    input  logic             inv,
    input  logic             od,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    output logic             pin,
    output logic             oe
);
    logic in_win;

    // Window test: equal points mean always active, otherwise a possibly wrapped span.
    always_comb begin
        if (rise == fall)     in_win = 1'b1;
        else if (rise < fall) in_win = (cnt >= rise) && (cnt < fall);
        else                  in_win = (cnt >= rise) || (cnt < fall);
    end

    assign pin = (run && drive && in_win) ^ inv;
    assign oe  = drive && !(od && pin);
endmodule

// File: rtl/dpwm_channel.sv
// One PWM channel: control register, two-stage prescaler, shadowed period
// counter and output stage. Control writes act on the next clock; duty
// writes follow the sync rules of the period block.
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_wdata,
    output logic              pwm_out,
    output logic              pwm_oe
);
    ctrl_t            ctrl_q;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    duty_t            live;

    // Control register: written whole, takes effect on the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    dpwm_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
        .dl(ctrl_q.dl), .dh(ctrl_q.dh), .tick(tick)
    );

    dpwm_period u_per (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .sync_off(ctrl_q.sync_off),
        .tick(tick), .wr(duty_wr), .wdata(duty_t'(duty_wdata)),
        .cnt(cnt), .live(live)
    );

    dpwm_outstage u_out (
        .run(ctrl_q.run), .drive(ctrl_q.drive), .inv(ctrl_q.inv), .od(ctrl_q.od),
        .cnt(cnt), .rise(live.rise), .fall(live.fall),
        .pin(pwm_out), .oe(pwm_oe)
    );

    // R6: writing drive low releases the pin on the next clock
    p_drive_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[B_DRIVE]) |=> !pwm_oe);

    // R10: in open-drain mode a high level is never driven
    p_od_no_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[B_OD]) |=> !(pwm_out && pwm_oe));
endmodule

// File: tb/dpwm_channel_test.sv
`timescale 1ns/1ps
module dpwm_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [16:0] ctrl_wdata = '0;
    logic        duty_wr = 1'b0;
    logic [23:0] duty_wdata = '0;
    logic        pwm_out, pwm_oe;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dpwm_channel uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    // Behavioural model state
    logic [16:0] m_ctrl;
    logic [23:0] m_pend, m_live;
    int m_pre, m_cnt;

    always @(posedge clk) begin
        int qlen, npre, ncnt;
        bit run, tk, wr_ap;
        logic [23:0] inc;
        started = 1;
        if (!rst_n) begin
            m_ctrl = '0; m_pend = '0; m_live = '0; m_pre = 0; m_cnt = 0;
        end else begin
            run = m_ctrl[15];
            qlen = (int'(m_ctrl[7:0]) + 1) << m_ctrl[11:8];
            inc = duty_wr ? duty_wdata : m_pend;
            tk = 0; wr_ap = 0;
            npre = 0; ncnt = 0;
            if (run) begin
                if (m_pre == qlen - 1) begin tk = 1; npre = 0; end
                else npre = m_pre + 1;
                ncnt = m_cnt;
                if (tk) begin
                    wr_ap = (m_cnt >= int'(m_live[23:16]));
                    ncnt = wr_ap ? 0 : m_cnt + 1;
                end
            end
            if (m_ctrl[16] || !run || wr_ap) m_live = inc;
            m_pend = inc;
            if (ctrl_wr) m_ctrl = ctrl_wdata;
            m_pre = npre; m_cnt = ncnt;
        end
    end

    function automatic bit exp_pin();
        int r, f;
        bit w;
        r = m_live[7:0]; f = m_live[15:8];
        if (r == f) w = 1;
        else if (r < f) w = (m_cnt >= r) && (m_cnt < f);
        else w = (m_cnt >= r) || (m_cnt < f);
        return (m_ctrl[15] && m_ctrl[12] && w) ^ m_ctrl[14];
    endfunction

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        bit ep, eo;
        if (started && !done) begin
            ep = exp_pin();
            eo = m_ctrl[12] && !(m_ctrl[13] && ep);
            checks++;
            if (pwm_out !== ep || pwm_oe !== eo) begin
                errors++;
                $display("FAIL %s: out/oe = %b%b expected %b%b at %0t", cur_req, pwm_out, pwm_oe, ep, eo, $time);
            end
        end
    end

    function automatic logic [16:0] mk_ctrl(bit so, bit run, bit inv, bit od, bit drv, int dh, int dl);
        return {so, run, inv, od, drv, 4'(dh), 8'(dl)};
    endfunction

    task automatic w_ctrl(logic [16:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic w_duty(int last, int fall, int rise);
        @(negedge clk); duty_wr = 1; duty_wdata = {8'(last), 8'(fall), 8'(rise)};
        @(negedge clk); duty_wr = 0;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(int n, output int hi, output int oe_hi, output int both);
        hi = 0; oe_hi = 0; both = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi += pwm_out; oe_hi += pwm_oe; both += (pwm_out && pwm_oe);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int h, o, b;
        repeat (4) @(negedge clk);
        check("R1", pwm_out, 0);
        check("R1", pwm_oe, 0);
        rst_n = 1;

        // Quantum 4 clocks, period 10 quanta = 40 clocks, window 2..5 -> 16 high
        cur_req = "R8";
        w_duty(9, 6, 2);
        cur_req = "R2";
        w_ctrl(mk_ctrl(0, 1, 0, 0, 1, 1, 1));
        measure(120, h, o, b);
        check("R3", h, 48);
        check("R2", o, 120);

        cur_req = "R4";
        w_duty(9, 5, 5);
        idle(50);
        measure(120, h, o, b);
        check("R4", h, 120);

        cur_req = "R3";
        w_duty(9, 3, 7);
        idle(50);
        measure(120, h, o, b);
        check("R3", h, 72);

        cur_req = "R7";
        w_ctrl(mk_ctrl(0, 1, 1, 0, 1, 1, 1));
        measure(120, h, o, b);
        check("R7", h, 48);
        w_ctrl(mk_ctrl(0, 1, 0, 0, 1, 1, 1));

        cur_req = "R8";
        idle(13);
        w_duty(9, 8, 1);
        idle(45);
        measure(120, h, o, b);
        check("R8", h, 84);

        cur_req = "R9";
        w_ctrl(mk_ctrl(1, 1, 0, 0, 1, 1, 1));
        idle(7);
        w_duty(9, 6, 2);
        measure(120, h, o, b);
        check("R9", h, 48);

        cur_req = "R5";
        w_ctrl(mk_ctrl(0, 0, 0, 0, 1, 1, 1));
        measure(40, h, o, b);
        check("R5", h, 0);
        check("R5", o, 40);
        w_ctrl(mk_ctrl(0, 1, 0, 0, 1, 1, 1));

        cur_req = "R6";
        idle(9);
        w_ctrl(mk_ctrl(0, 1, 0, 0, 0, 1, 1));
        measure(40, h, o, b);
        check("R6", h, 0);
        check("R6", o, 0);

        cur_req = "R10";
        w_ctrl(mk_ctrl(0, 1, 0, 1, 1, 1, 1));
        measure(120, h, o, b);
        check("R10", b, 0);
        check("R10", o, 72);

        // Other divider: quantum 8 clocks, period 5 quanta, window 1..2 -> 16 per 40
        cur_req = "R2";
        w_ctrl(mk_ctrl(0, 0, 0, 0, 1, 3, 0));
        w_duty(4, 3, 1);
        w_ctrl(mk_ctrl(0, 1, 0, 0, 1, 3, 0));
        measure(120, h, o, b);
        check("R2", h, 48);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule